// File: doc/BRIEF.md
# Serial-Controlled 32-Way Switch Select Decoder

This block is the digital control front end for a bank of 32 analog switches that share one common output node. A host loads an 8-bit control word over a three-wire serial link: an active-low frame strobe, a serial clock and a data line. The block samples all three lines with a faster system clock and decodes the word into 32 one-hot switch enables. When a different channel is picked, the block always opens the old switch first. It then holds every switch open for a fixed dead time and only after that closes the new one.

The serial lines pass through two-flop synchronizers, and their edges are found in the system-clock domain. For this reason the system clock must run at least four times faster than the serial clock. A word takes effect when the frame strobe rises, and only if exactly eight serial-clock falling edges were counted while the strobe was low. Words with the select bit clear are dropped. The dead time is a parameter in system-clock cycles and defaults to three.

Top module: `serial_switch_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, all 32 switch enables are 0.
- R2: A frame is the time the strobe `frame_n_i` is low. On each falling edge of `sclk_i` inside a frame, one bit of `sdata_i` is shifted in, most significant bit first. Word bit 7 is the disable flag, bit 6 is the select flag, bit 5 is unused, and bits 4..0 are the channel address. A valid word with select=1 and disable=0 drives enable bit `addr` of `sw_en_o`.
- R3: A valid word with select=1 and disable=1 turns all enables off.
- R4: A word with select=0 has no effect on the enables.
- R5: When the strobe rises after a frame with other than 8 falling clock edges, the enables do not change.
- R6: No more than one enable is ever 1.
- R7: On a change from one on-channel to another, every enable is 0 for exactly DEAD_CYC system cycles (default 3) before the new channel turns on.
- R8: Loading the address of the channel that is already on causes no change at all on the enables.
- R9: From the all-off state, the new channel turns on with no dead time. It does so on the 4th system-clock rising edge after the strobe rises.
- R10: Bit 5 of the word does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; idles high, data captured on falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| frame_n_i | input | 1 | Active-low frame strobe |
| sw_en_o | output | 32 | One-hot switch enables (bit n closes channel n) |

## Verification
The assertions check three things on every cycle: at most one enable is high, an on-channel never moves straight to a different channel, and a turn-on after a prior on-period is preceded by at least DEAD_CYC all-off cycles. They also check that the enables are zero while reset is held. Some behaviour only the bench scenarios can show. These are the field meanings, the MSB-first bit order, dropped frames with short or long bit counts, the select bit and the unused bit, the exact dead time, the silence on reselecting the current channel, and the fixed latency from the strobe's rising edge when starting from all-off. The bench drives all 32 addresses in turn.

// File: rtl/sw_ctrl_pkg.sv
package sw_ctrl_pkg;
  localparam int unsigned CH_ADDR_W = 5;
  localparam int unsigned CH_COUNT  = 1 << CH_ADDR_W;
  localparam int unsigned CWORD_W   = 3 + CH_ADDR_W;

  // Field order matters: the first serial bit lands in the top field.
  typedef struct packed {
    logic                 dis;
    logic                 sel;
    logic                 spare;
    logic [CH_ADDR_W-1:0] addr;
  } ctrl_word_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_GAP  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sw_rst_sync.sv
module sw_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;
endmodule

// File: rtl/sw_frame_rx.sv
module sw_frame_rx
  import sw_ctrl_pkg::*;
#(
  parameter int unsigned WORD_W = CWORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              data_s,
  input  logic              frame_n_s,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam int unsigned CNT_SAT = WORD_W + 1;

  logic              sclk_q, frame_q;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              sclk_fall, frame_fall, frame_rise;

  assign sclk_fall  = sclk_q & ~sclk_s;
  assign frame_fall = frame_q & ~frame_n_s;
  assign frame_rise = ~frame_q & frame_n_s;

  always_comb begin
    shift_d = shift_q;
    cnt_d   = cnt_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    if (frame_fall) begin
      cnt_d = '0;
    end else if (!frame_n_s && sclk_fall) begin
      shift_d = {shift_q[WORD_W-2:0], data_s};
      if (cnt_q != CNT_W'(CNT_SAT)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (frame_rise && (cnt_q == CNT_W'(WORD_W))) begin
      vld_d  = 1'b1;
      word_d = shift_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      sclk_q  <= sclk_s;
      frame_q <= frame_n_s;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      vld_q   <= vld_d;
      word_q  <= word_d;
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = word_q;
endmodule

// File: rtl/sw_bbm_seq.sv
module sw_bbm_seq
  import sw_ctrl_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_vld_i,
  input  ctrl_word_t           word_i,
  output logic                 on_o,
  output logic [CH_ADDR_W-1:0] addr_o
);
  localparam int unsigned CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);

  seq_state_t           st_q, st_d;
  logic                 on_q, on_d;
  logic [CH_ADDR_W-1:0] addr_q, addr_d;
  logic [CH_ADDR_W-1:0] pend_q, pend_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 take, tgt_on;

  assign take   = word_vld_i & word_i.sel;
  assign tgt_on = ~word_i.dis;

  always_comb begin
    st_d   = st_q;
    on_d   = on_q;
    addr_d = addr_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (take) begin
          if (!on_q) begin
            if (tgt_on) begin
              on_d   = 1'b1;
              addr_d = word_i.addr;
            end
          end else if (!tgt_on) begin
            on_d = 1'b0;
          end else if (word_i.addr != addr_q) begin
            on_d   = 1'b0;
            pend_d = word_i.addr;
            cnt_d  = CNT_W'(DEAD_CYC - 1);
            st_d   = SEQ_GAP;
          end
        end
      end
      SEQ_GAP: begin
        if (take && !tgt_on) begin
          st_d = SEQ_IDLE;
        end else begin
          if (take) begin
            pend_d = word_i.addr;
          end
          if (cnt_q == '0) begin
            on_d   = 1'b1;
            addr_d = pend_d;
            st_d   = SEQ_IDLE;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      on_q   <= 1'b0;
      addr_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      on_q   <= on_d;
      addr_q <= addr_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign on_o   = on_q;
  assign addr_o = addr_q;
endmodule

// File: rtl/sw_onehot_dec.sv
module sw_onehot_dec #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned N_OUT  = 1 << ADDR_W
) (
  input  logic              on_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_OUT-1:0]  en_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_dec
    assign en_o[g] = on_i & (addr_i == ADDR_W'(g));
  end
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl
  import sw_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CH   = CH_COUNT,
  parameter int unsigned DEAD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              frame_n_i,
  output logic [NUM_CH-1:0] sw_en_o
);
  logic                 rst_n_s;
  logic [2:0]           pins_s;
  logic                 word_vld;
  logic [CWORD_W-1:0]   word_raw;
  ctrl_word_t           word;
  logic                 sel_on;
  logic [CH_ADDR_W-1:0] sel_addr;

  sw_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  sw_sync #(.WIDTH(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .async_i ({frame_n_i, sdata_i, sclk_i}),
    .sync_o  (pins_s)
  );

  sw_frame_rx #(.WORD_W(CWORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .sclk_s     (pins_s[0]),
    .data_s     (pins_s[1]),
    .frame_n_s  (pins_s[2]),
    .word_vld_o (word_vld),
    .word_o     (word_raw)
  );

  assign word = ctrl_word_t'(word_raw);

  sw_bbm_seq #(.DEAD_CYC(DEAD_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .word_vld_i (word_vld),
    .word_i     (word),
    .on_o       (sel_on),
    .addr_o     (sel_addr)
  );

  sw_onehot_dec #(.ADDR_W(CH_ADDR_W), .N_OUT(NUM_CH)) u_dec (
    .on_i   (sel_on),
    .addr_i (sel_addr),
    .en_o   (sw_en_o)
  );
endmodule

// File: rtl/serial_switch_ctrl_chk.sv
module serial_switch_ctrl_chk #(
  parameter int unsigned NUM_CH   = 32,
  parameter int unsigned DEAD_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] sw_en_o
);
  localparam int unsigned OC_W = $clog2(DEAD_CYC + 2);

  logic [OC_W-1:0] off_cnt_q;
  logic            had_on_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_cnt_q <= '0;
      had_on_q  <= 1'b0;
    end else begin
      if (sw_en_o != '0) begin
        off_cnt_q <= '0;
        had_on_q  <= 1'b1;
      end else if (off_cnt_q != OC_W'(DEAD_CYC)) begin
        off_cnt_q <= off_cnt_q + 1'b1;
      end
    end
  end

  // R1
  reset_off_chk: assert property (@(posedge clk) !rst_n |-> (sw_en_o == '0));

  // R6
  single_on_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sw_en_o));

  // R7
  no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sw_en_o) != '0) && (sw_en_o != '0)) |-> (sw_en_o == $past(sw_en_o)));

  // R7
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (had_on_q && ($past(sw_en_o) == '0) && (sw_en_o != '0)) |-> (off_cnt_q >= OC_W'(DEAD_CYC)));
endmodule

bind serial_switch_ctrl serial_switch_ctrl_chk #(
  .NUM_CH   (NUM_CH),
  .DEAD_CYC (DEAD_CYC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_en_o (sw_en_o)
);

// File: tb/serial_switch_ctrl_tb.sv
`timescale 1ns/1ps
module serial_switch_ctrl_tb;
  localparam int NCH  = 32;
  localparam int DEAD = 3;
  localparam int HALF = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sclk, sdata, frame_n;
  logic [NCH-1:0] sw_en;

  int checks = 0;
  int errors = 0;
  int chg_cnt = 0;
  int multi_on = 0;
  int last_gap = -1;
  int run = 0;
  bit had_on = 0;
  logic [NCH-1:0] prev_en = '0;

  always #4 clk = ~clk;

  serial_switch_ctrl #(.NUM_CH(NCH), .DEAD_CYC(DEAD)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_i    (sclk),
    .sdata_i   (sdata),
    .frame_n_i (frame_n),
    .sw_en_o   (sw_en)
  );

  always @(negedge clk) begin
    if ($countones(sw_en) > 1) multi_on++;
    if (sw_en !== prev_en) chg_cnt++;
    if (sw_en == '0) begin
      run++;
    end else begin
      if (prev_en == '0 && had_on) last_gap = run;
      run = 0;
      had_on = 1;
    end
    prev_en = sw_en;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends the lowest nbits of val, MSB first; returns right after the strobe rises.
  task automatic send_frame(input logic [15:0] val, input int nbits);
    @(negedge clk);
    frame_n = 1'b0;
    wait_clk(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = val[i];
      wait_clk(HALF);
      sclk = 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
    end
    wait_clk(HALF);
    frame_n = 1'b1;
  endtask

  function automatic logic [7:0] mkw(input bit dis, input bit sel, input bit sp, input int a);
    return {dis, sel, sp, 5'(a)};
  endfunction

  initial begin
    int snap;
    rst_n = 1'b0; sclk = 1'b1; sdata = 1'b0; frame_n = 1'b1;
    wait_clk(3);
    check(sw_en == '0, "R1 during reset", sw_en, 0);
    rst_n = 1'b1;
    wait_clk(6);
    check(sw_en == '0, "R1 after reset", sw_en, 0);

    // R2 / R7 sweep over all channels
    for (int ch = 0; ch < NCH; ch++) begin
      last_gap = -1;
      send_frame(16'(mkw(0, 1, 0, ch)), 8);
      wait_clk(14);
      check(sw_en == (32'd1 << ch), "R2 address decode", sw_en, 32'd1 << ch);
      if (ch > 0) check(last_gap == DEAD, "R7 dead time", last_gap, DEAD);
    end
    check(multi_on == 0, "R6 single enable", multi_on, 0);

    // R8 reselect current channel
    snap = chg_cnt;
    send_frame(16'(mkw(0, 1, 0, 31)), 8);
    wait_clk(14);
    check(chg_cnt == snap && sw_en == (32'd1 << 31), "R8 reselect silent", chg_cnt - snap, 0);

    // R10 unused bit set
    send_frame(16'(mkw(0, 1, 1, 5)), 8);
    wait_clk(14);
    check(sw_en == (32'd1 << 5), "R10 spare bit ignored", sw_en, 32'd1 << 5);

    // R4 select clear
    send_frame(16'(mkw(0, 0, 0, 9)), 8);
    wait_clk(14);
    check(sw_en == (32'd1 << 5), "R4 select clear dropped", sw_en, 32'd1 << 5);

    // R5 short and long frames
    send_frame(16'(mkw(0, 1, 0, 9)), 7);
    wait_clk(14);
    check(sw_en == (32'd1 << 5), "R5 7-bit frame dropped", sw_en, 32'd1 << 5);
    send_frame({8'h00, mkw(0, 1, 0, 9)} << 1, 9);
    wait_clk(14);
    check(sw_en == (32'd1 << 5), "R5 9-bit frame dropped", sw_en, 32'd1 << 5);

    // R3 disable
    send_frame(16'(mkw(1, 1, 0, 20)), 8);
    wait_clk(14);
    check(sw_en == '0, "R3 disable all off", sw_en, 0);

    // R9 turn-on from all-off: fixed latency, no gap
    send_frame(16'(mkw(0, 1, 0, 12)), 8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sw_en == '0, "R9 not yet on at 3rd edge", sw_en, 0);
    @(posedge clk);
    @(negedge clk);
    check(sw_en == (32'd1 << 12), "R9 on at 4th edge", sw_en, 32'd1 << 12);

    // R2 bit order: reversed address must not be taken as 12
    send_frame(16'(mkw(0, 1, 0, 6)), 8);
    wait_clk(14);
    check(sw_en == (32'd1 << 6), "R2 MSB first", sw_en, 32'd1 << 6);

    // R3 with select clear does nothing
    send_frame(16'(mkw(1, 0, 0, 0)), 8);
    wait_clk(14);
    check(sw_en == (32'd1 << 6), "R4 disable without select dropped", sw_en, 32'd1 << 6);

    check(multi_on == 0, "R6 single enable at end", multi_on, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule